// File: doc/BRIEF.md
# Keyed Configuration Register File

This block is the configuration space of a multi-function I/O controller. It sits on an 8-bit I/O bus and has two ports, chosen by address bit 0: the index port (bit 0 = 0) and the data port (bit 0 = 1). Software unlocks the space by writing a two-byte key to the index port. It then picks a register by writing its number to the index port, and reads or writes that register through the data port. Writing an exit byte to the index port closes the space again.

The file holds 42 byte-wide registers, each with a fixed reset value. Every register is driven onto a flat parallel output, so downstream decode logic can use the settings without any bus access.

Two rules limit access. Some registers are read-only. A protection lock, controlled by one bit of register 1, hides the low registers from both reads and writes.

The bus side has no back-pressure. Read and write strobes are single-cycle synchronous pulses, and the block accepts every strobe. Read data is combinational and is valid in the same cycle as the read strobe. The block drives zero on the read data when no read strobe is present.

Top module: `cfg_keyed_regfile`

## Requirements
- R1: Configuration mode is entered only after two consecutive index-port writes of 0x55 made while outside configuration mode.
- R2: Outside configuration mode, any index-port write other than 0x55 cancels a pending first key byte, so the next 0x55 counts as a first key byte again.
- R3: In configuration mode, an index-port write of 0xAA leaves configuration mode. After that, reads return 0xFF again.
- R4: In configuration mode, an index-port write of a value below 42 sets the current index to that value. Any larger value leaves the index unchanged. The current index is always below 42.
- R5: Outside configuration mode, a read of either port returns 0xFF, and data-port writes change no register.
- R6: In configuration mode, an index-port read returns the current index, and a data-port read returns the register the index selects. This holds in the same cycle as the read strobe.
- R7: Data-port writes to registers 0x26, 0x27 and 0x29 are ignored.
- R8: A data write to register 1 with bit 3 = 0 sets the protection lock, and one with bit 3 = 1 clears it. While the lock is set, registers 0x00 to 0x17 ignore data writes and read back as 0xFF. Registers 0x18 and above are not affected by the lock.
- R9: Reset values are as follows. 0x00=0x28, 0x01=0x9C, 0x02=0x88, 0x03=0x78, 0x06=0xFF, 0x0D=0x03, 0x0E=0x02, 0x1E=0x80, 0x20=0xFC, 0x21=0x7C, 0x22=0xFD, 0x23=0xDE, 0x24=0xFE, 0x25=0xBE, 0x26=0x23, 0x27=0x67, 0x28=0x43. Every other register resets to 0.
- R10: Reset leaves configuration mode, clears the protection lock, clears any pending key byte and sets the current index to 0.
- R11: Register n appears at bits [8n+7:8n] of the parallel register output at all times, whatever the mode or lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_port_sel | input | 1 | Address bit 0: 0 = index port, 1 = data port |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high, else 0 |
| cfg_regs | output | 336 | All registers, register n at bits [8n+7:8n] |

## Verification
The bench writes a key, then an unrelated byte, then the key twice. A design that counted key bytes without resetting the count would open the space one write too early, and the index-port read that follows would no longer return 0xFF. It sweeps all 256 index values, which catches an index compare that is off by one at 42 or that takes values it should drop. It writes every register and checks the three read-only ones, so a missing write block shows up as a changed byte. With the lock set, it probes registers 0x17 and 0x18, which catches a lock boundary in the wrong place. A reset in the middle of the run must bring back every default value and release the lock. A design that kept the lock through reset would then fail the write-back to a low register.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;

  localparam int CFG_NUM_REGS   = 42;
  localparam int CFG_DW         = 8;
  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam int GUARD_LIMIT    = 'h18;  // registers below this are lock-guarded
  localparam int GUARD_REG      = 1;     // register that owns the lock bit
  localparam int GUARD_BIT      = 3;     // 0 written here arms the lock

  // bus port decoded from address bit 0
  typedef enum logic {PORT_INDEX = 1'b0, PORT_DATA = 1'b1} port_e;

  function automatic logic [7:0] reg_reset_value(input int n);
    logic [7:0] v;
    case (n)
      'h00: v = 8'h28;
      'h01: v = 8'h9C;
      'h02: v = 8'h88;
      'h03: v = 8'h78;
      'h06: v = 8'hFF;
      'h0D: v = 8'h03;
      'h0E: v = 8'h02;
      'h1E: v = 8'h80;
      'h20: v = 8'hFC;
      'h21: v = 8'h7C;
      'h22: v = 8'hFD;
      'h23: v = 8'hDE;
      'h24: v = 8'hFE;
      'h25: v = 8'hBE;
      'h26: v = 8'h23;
      'h27: v = 8'h67;
      'h28: v = 8'h43;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic bit reg_is_fixed(input int n);
    return (n == 'h26) || (n == 'h27) || (n == 'h29);
  endfunction

endpackage

// File: rtl/cfg_key_seq.sv
module cfg_key_seq
  import cfg_regfile_pkg::*;
#(
  parameter int DW = CFG_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic [DW-1:0] wdata,
  output logic          mode
);
  logic half_key_q;
  logic mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_key_q <= 1'b0;
      mode_q     <= 1'b0;
    end else if (idx_wr) begin
      if (!mode_q) begin
        if (wdata == DW'(KEY_OPEN)) begin
          if (half_key_q) begin
            mode_q     <= 1'b1;
            half_key_q <= 1'b0;
          end else begin
            half_key_q <= 1'b1;
          end
        end else begin
          half_key_q <= 1'b0;
        end
      end else if (wdata == DW'(KEY_CLOSE)) begin
        mode_q <= 1'b0;
      end
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
  import cfg_regfile_pkg::*;
#(
  parameter int DW       = CFG_DW,
  parameter int NUM_REGS = CFG_NUM_REGS,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic          mode,
  input  logic [DW-1:0] wdata,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] idx_q;
  logic          in_range;

  assign in_range = int'(wdata) < NUM_REGS;

  always_ff @(posedge clk) begin
    if (!rst_n)                           idx_q <= '0;
    else if (idx_wr && mode && in_range)  idx_q <= wdata[IW-1:0];
  end

  assign idx = idx_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_regfile_pkg::*;
#(
  parameter int DW       = CFG_DW,
  parameter int NUM_REGS = CFG_NUM_REGS,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dat_wr,
  input  logic                   mode,
  input  logic [IW-1:0]          idx,
  input  logic [DW-1:0]          wdata,
  output logic                   lock,
  output logic [NUM_REGS*DW-1:0] regs_flat
);
  logic lock_q;
  logic guarded;
  logic wr_ok;

  assign guarded = lock_q && (int'(idx) < GUARD_LIMIT);
  assign wr_ok   = dat_wr && mode && !guarded;

  generate
    for (genvar n = 0; n < NUM_REGS; n++) begin : g_reg
      if (reg_is_fixed(n)) begin : g_fixed
        assign regs_flat[n*DW +: DW] = DW'(reg_reset_value(n));
      end else begin : g_rw
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
          if (!rst_n)                          q <= DW'(reg_reset_value(n));
          else if (wr_ok && idx == IW'(n))     q <= wdata;
        end
        assign regs_flat[n*DW +: DW] = q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                                  lock_q <= 1'b0;
    else if (wr_ok && idx == IW'(GUARD_REG))     lock_q <= ~wdata[GUARD_BIT];
  end

  assign lock = lock_q;
endmodule

// File: rtl/cfg_read_path.sv
module cfg_read_path
  import cfg_regfile_pkg::*;
#(
  parameter int DW       = CFG_DW,
  parameter int NUM_REGS = CFG_NUM_REGS,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic                   rd,
  input  logic                   port_sel,
  input  logic                   mode,
  input  logic                   lock,
  input  logic [IW-1:0]          idx,
  input  logic [NUM_REGS*DW-1:0] regs_flat,
  output logic [DW-1:0]          rdata
);
  always_comb begin
    rdata = '0;
    if (rd) begin
      if (!mode)                                           rdata = '1;
      else if (port_sel == PORT_INDEX)                     rdata = DW'(idx);
      else if (lock && (int'(idx) < GUARD_LIMIT))          rdata = '1;
      else                                                 rdata = regs_flat[int'(idx)*DW +: DW];
    end
  end
endmodule

// File: rtl/cfg_keyed_regfile.sv
module cfg_keyed_regfile
  import cfg_regfile_pkg::*;
#(
  parameter int DW       = CFG_DW,
  parameter int NUM_REGS = CFG_NUM_REGS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_port_sel,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  output logic [NUM_REGS*DW-1:0] cfg_regs
);
  localparam int IW = $clog2(NUM_REGS);

  logic          idx_wr, dat_wr;
  logic          mode_w, lock_w;
  logic [IW-1:0] idx_w;

  assign idx_wr = bus_wr && (bus_port_sel == PORT_INDEX);
  assign dat_wr = bus_wr && (bus_port_sel == PORT_DATA);

  cfg_key_seq #(.DW(DW)) u_key (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(bus_wdata), .mode(mode_w)
  );

  cfg_index_reg #(.DW(DW), .NUM_REGS(NUM_REGS)) u_idx (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .mode(mode_w),
    .wdata(bus_wdata), .idx(idx_w)
  );

  cfg_reg_bank #(.DW(DW), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .mode(mode_w), .idx(idx_w),
    .wdata(bus_wdata), .lock(lock_w), .regs_flat(cfg_regs)
  );

  cfg_read_path #(.DW(DW), .NUM_REGS(NUM_REGS)) u_rd (
    .rd(bus_rd), .port_sel(bus_port_sel), .mode(mode_w), .lock(lock_w),
    .idx(idx_w), .regs_flat(cfg_regs), .rdata(bus_rdata)
  );
endmodule

// File: rtl/cfg_regfile_checker.sv
module cfg_regfile_checker #(
  parameter int DW       = 8,
  parameter int NUM_REGS = 42,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   port_sel,
  input logic                   wr,
  input logic                   rd,
  input logic [DW-1:0]          wdata,
  input logic [DW-1:0]          rdata,
  input logic                   mode,
  input logic                   lock,
  input logic [IW-1:0]          idx,
  input logic [NUM_REGS*DW-1:0] regs
);
  p_enter_after_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode) |-> $past(wr && !port_sel && wdata == DW'(8'h55)));

  p_close_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && wr && !port_sel && wdata == DW'(8'hAA)) |=> !mode);

  p_index_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < NUM_REGS);

  p_closed_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && rd) |-> rdata == '1);

  p_closed_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && wr && port_sel) |=> $stable(regs));

  p_fixed_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs[DW*'h26 +: 2*DW]) && $stable(regs[DW*'h29 +: DW]));

  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock && $stable(regs[DW*'h18-1:0]));
endmodule

bind cfg_keyed_regfile cfg_regfile_checker #(.DW(DW), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_sel(bus_port_sel), .wr(bus_wr), .rd(bus_rd),
  .wdata(bus_wdata), .rdata(bus_rdata), .mode(mode_w), .lock(lock_w),
  .idx(idx_w), .regs(cfg_regs)
);

// File: tb/sim_cfg_keyed_regfile.sv
`timescale 1ns/1ps
module sim_cfg_keyed_regfile;
  localparam int N = 42;
  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [N*8-1:0] regs;
  int checks = 0, fails = 0;
  logic [7:0] model [N];

  always #4 clk = ~clk;

  cfg_keyed_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_port_sel(sel), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .cfg_regs(regs)
  );

  function automatic logic [7:0] dflt(input int n);
    case (n)
      0: return 8'h28;  1: return 8'h9C;  2: return 8'h88;  3: return 8'h78;
      6: return 8'hFF;  13: return 8'h03; 14: return 8'h02; 30: return 8'h80;
      32: return 8'hFC; 33: return 8'h7C; 34: return 8'hFD; 35: return 8'hDE;
      36: return 8'hFE; 37: return 8'hBE; 38: return 8'h23; 39: return 8'h67;
      40: return 8'h43; default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic p, input logic [7:0] v);
    @(negedge clk); sel = p; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic p, output logic [7:0] v);
    @(negedge clk); sel = p; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) model[i] = dflt(i);
  endtask

  task automatic check_defaults(input string tag);
    for (int i = 0; i < N; i++) chk(tag, regs[i*8 +: 8], dflt(i));
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_idx;
    do_reset();
    // R9 R11: every default visible on the parallel output
    check_defaults("R9 default");
    // R5 R10: closed after reset
    bus_rd(1'b0, v); chk("R10 closed index read", v, 8'hFF);
    bus_rd(1'b1, v); chk("R5 closed data read", v, 8'hFF);
    bus_wr(1'b1, 8'h11);
    chk("R5 closed data write ignored", regs[7:0], 8'h28);
    // R2: interrupted key does not open
    bus_wr(1'b0, 8'h55); bus_wr(1'b0, 8'h12); bus_wr(1'b0, 8'h55);
    bus_rd(1'b0, v); chk("R2 cancelled key", v, 8'hFF);
    // R1: second consecutive key opens; R10 index starts at 0
    bus_wr(1'b0, 8'h55);
    bus_rd(1'b0, v); chk("R1 open, R10 index 0", v, 8'h00);
    bus_rd(1'b1, v); chk("R6 data read reg0", v, 8'h28);
    // R4: sweep of all index values except the exit key
    exp_idx = 8'h00;
    for (int k = 0; k < 256; k++) begin
      if (k != 'hAA) begin
        bus_wr(1'b0, 8'(k));
        if (k < N) exp_idx = 8'(k);
        bus_rd(1'b0, v); chk("R4 index sweep", v, exp_idx);
      end
    end
    // R6 R7 R11: write every register, bit 3 of reg1 stays 1
    for (int i = 0; i < N; i++) begin
      bus_wr(1'b0, 8'(i));
      bus_wr(1'b1, 8'(i) ^ 8'h5A);
      if (!(i == 'h26 || i == 'h27 || i == 'h29)) model[i] = 8'(i) ^ 8'h5A;
      bus_rd(1'b1, v);
      chk((i == 'h26 || i == 'h27 || i == 'h29) ? "R7 fixed reg" : "R6 data rw", v, model[i]);
      chk("R11 parallel view", regs[i*8 +: 8], model[i]);
    end
    // R8: arm the lock
    bus_wr(1'b0, 8'h01); bus_wr(1'b1, 8'h00);
    chk("R8 reg1 written", regs[15:8], 8'h00);
    bus_rd(1'b1, v); chk("R8 locked reg1 read", v, 8'hFF);
    bus_wr(1'b0, 8'h05); bus_wr(1'b1, 8'h77);
    chk("R8 locked write ignored", regs[5*8 +: 8], model[5]);
    bus_rd(1'b1, v); chk("R8 locked reg5 read", v, 8'hFF);
    bus_wr(1'b0, 8'h17); bus_wr(1'b1, 8'h66);
    chk("R8 boundary 0x17 ignored", regs['h17*8 +: 8], model['h17]);
    bus_rd(1'b1, v); chk("R8 boundary 0x17 read", v, 8'hFF);
    bus_rd(1'b0, v); chk("R8 index still readable", v, 8'h17);
    bus_wr(1'b0, 8'h18); bus_wr(1'b1, 8'h99);
    bus_rd(1'b1, v); chk("R8 0x18 unaffected", v, 8'h99);
    chk("R8 0x18 parallel", regs['h18*8 +: 8], 8'h99);
    // R3: exit key closes
    bus_wr(1'b0, 8'hAA);
    bus_rd(1'b0, v); chk("R3 closed index read", v, 8'hFF);
    bus_rd(1'b1, v); chk("R3 closed data read", v, 8'hFF);
    // R10: reset mid-run restores defaults and releases the lock
    bus_wr(1'b0, 8'h55);          // leave a pending key byte before reset
    do_reset();
    check_defaults("R10 defaults after reset");
    bus_wr(1'b0, 8'h55);
    bus_rd(1'b0, v); chk("R10 key count cleared", v, 8'hFF);
    bus_wr(1'b0, 8'h55);
    bus_rd(1'b0, v); chk("R10 index reset", v, 8'h00);
    bus_wr(1'b0, 8'h05); bus_wr(1'b1, 8'h33);
    bus_rd(1'b1, v); chk("R10 lock released", v, 8'h33);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule